// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit holds the transmit and receive queues of a serial peripheral controller and turns their fill state into level counts, a status word and a set of maskable interrupts. The bus side pushes transmit words and pops receive words. The serial engine pops transmit words and pushes receive words. Both queues have the same depth, set by a parameter to 32 or 64 words. The depth must be a power of two.

Software writes a transmit threshold and a receive threshold while the controller is disabled. These set when the "transmit low" and "receive ready" interrupts fire. Error events are sticky:

- a push into a full transmit queue,
- a push into a full receive queue,
- a pop from an empty receive queue.

Each sticky event stays set until a strobe on the clear word removes it. When the controller enable goes low, both queues are emptied.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After reset, both levels are 0, both thresholds are 0 and all sticky flags are clear.
- R2: Each queue returns words in the order they were pushed. The level reports the number of words held, from 0 to DEPTH. The read data port shows the oldest word and reads 0 when the queue is empty.
- R3: A transmit push while the transmit level equals DEPTH is dropped. It leaves the level and the stored contents unchanged and sets raw interrupt bit 1 (transmit overflow).
- R4: A receive push while the receive queue is full is dropped and sets raw bit 3 (receive overflow). A receive pop while the receive queue is empty reads 0 and sets raw bit 2 (receive underflow).
- R5: The status word is laid out as follows:
  - bit 0 is the engine busy input,
  - bit 1 is transmit full,
  - bit 2 is transmit empty,
  - bit 3 is receive empty,
  - bit 4 is receive full,
  - bit 5 is the slave transmit busy input.
- R6: Raw bit 0 is high whenever the transmit level is less than or equal to the transmit threshold.
- R7: Raw bit 4 is high whenever the receive level is greater than the receive threshold, so a threshold of N fires once N+1 words are held.
- R8: The masked vector is the raw vector ANDed with the 5-bit mask. The interrupt line is the OR of the masked bits.
- R9: Clear word bits act as one-cycle strobes:
  - bit 0 clears all three sticky flags,
  - bit 1 clears receive underflow,
  - bit 2 clears receive overflow,
  - bit 3 clears transmit overflow.

  If an event and its clear happen in the same cycle, the event wins.
- R10: While the enable is low, both levels are 0 from the next cycle on. Pushes and pops have no effect and raise no flag during that time.
- R11: A threshold write takes effect only while the enable is low. A write made while the enable is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; low flushes both queues |
| busy_in | input | 1 | Engine busy, reported in status bit 0 |
| slave_tx_busy_in | input | 1 | Slave transmit busy, reported in status bit 5 |
| tx_push | input | 1 | Bus-side transmit push strobe |
| tx_wdata | input | WIDTH | Transmit push data |
| tx_pop | input | 1 | Engine-side transmit pop strobe |
| tx_rdata | output | WIDTH | Oldest transmit word, or 0 when empty |
| rx_push | input | 1 | Engine-side receive push strobe |
| rx_wdata | input | WIDTH | Receive push data |
| rx_pop | input | 1 | Bus-side receive pop strobe |
| rx_rdata | output | WIDTH | Oldest receive word, or 0 when empty |
| tx_thr_wr | input | 1 | Transmit threshold write strobe |
| tx_thr_in | input | $clog2(DEPTH)+1 | Transmit threshold value |
| rx_thr_wr | input | 1 | Receive threshold write strobe |
| rx_thr_in | input | $clog2(DEPTH)+1 | Receive threshold value |
| irq_mask | input | 5 | Interrupt enable mask |
| clr_bits | input | 4 | Sticky clear strobes |
| tx_level | output | $clog2(DEPTH)+1 | Transmit words held |
| rx_level | output | $clog2(DEPTH)+1 | Receive words held |
| status | output | 6 | Status word |
| raw_irq | output | 5 | Raw interrupt vector |
| masked_irq | output | 5 | Masked interrupt vector |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the unit with DEPTH=32 and WIDTH=8. The small word width keeps the data patterns readable. The 32-entry depth is shallow enough to fill both queues completely in a short loop, which brings the full flags, both overflow drops and the full-level boundary of the threshold compares within reach. The receive threshold is set to 2. With that value, a table of pushes and pops walks the receive interrupt across its 2-to-3 word edge in both directions.

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable,
  input  logic                       busy_in,
  input  logic                       slave_tx_busy_in,
  input  logic                       tx_push,
  input  logic [WIDTH-1:0]           tx_wdata,
  input  logic                       tx_pop,
  output logic [WIDTH-1:0]           tx_rdata,
  input  logic                       rx_push,
  input  logic [WIDTH-1:0]           rx_wdata,
  input  logic                       rx_pop,
  output logic [WIDTH-1:0]           rx_rdata,
  input  logic                       tx_thr_wr,
  input  logic [$clog2(DEPTH):0]     tx_thr_in,
  input  logic                       rx_thr_wr,
  input  logic [$clog2(DEPTH):0]     rx_thr_in,
  input  logic [4:0]                 irq_mask,
  input  logic [3:0]                 clr_bits,
  output logic [$clog2(DEPTH):0]     tx_level,
  output logic [$clog2(DEPTH):0]     rx_level,
  output logic [5:0]                 status,
  output logic [4:0]                 raw_irq,
  output logic [4:0]                 masked_irq,
  output logic                       irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [WIDTH-1:0] tx_mem [DEPTH];
  logic [WIDTH-1:0] rx_mem [DEPTH];
  logic [AW-1:0]    tx_wp, tx_rp, rx_wp, rx_rp;
  logic [LW-1:0]    tx_cnt, rx_cnt, tx_thr, rx_thr;
  logic             tx_ovf, rx_ovf, rx_unf;

  wire tx_full  = (tx_cnt == FULL_LVL);
  wire tx_empty = (tx_cnt == '0);
  wire rx_full  = (rx_cnt == FULL_LVL);
  wire rx_empty = (rx_cnt == '0);

  wire tx_wr = enable & tx_push & ~tx_full;
  wire tx_rd = enable & tx_pop  & ~tx_empty;
  wire rx_wr = enable & rx_push & ~rx_full;
  wire rx_rd = enable & rx_pop  & ~rx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (!enable) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_wr) tx_wp <= tx_wp + 1'b1;
      if (tx_rd) tx_rp <= tx_rp + 1'b1;
      if (rx_wr) rx_wp <= rx_wp + 1'b1;
      if (rx_rd) rx_rp <= rx_rp + 1'b1;
      tx_cnt <= tx_cnt + LW'(tx_wr) - LW'(tx_rd);
      rx_cnt <= rx_cnt + LW'(rx_wr) - LW'(rx_rd);
    end
  end

  always_ff @(posedge clk) begin
    if (tx_wr) tx_mem[tx_wp] <= tx_wdata;
    if (rx_wr) rx_mem[rx_wp] <= rx_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr <= '0;
      rx_thr <= '0;
    end else if (!enable) begin
      if (tx_thr_wr) tx_thr <= tx_thr_in;
      if (rx_thr_wr) rx_thr <= rx_thr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ovf <= 1'b0;
      rx_ovf <= 1'b0;
      rx_unf <= 1'b0;
    end else begin
      tx_ovf <= (tx_ovf & ~(clr_bits[0] | clr_bits[3])) | (enable & tx_push & tx_full);
      rx_ovf <= (rx_ovf & ~(clr_bits[0] | clr_bits[2])) | (enable & rx_push & rx_full);
      rx_unf <= (rx_unf & ~(clr_bits[0] | clr_bits[1])) | (enable & rx_pop & rx_empty);
    end
  end

  assign tx_rdata   = tx_empty ? '0 : tx_mem[tx_rp];
  assign rx_rdata   = rx_empty ? '0 : rx_mem[rx_rp];
  assign tx_level   = tx_cnt;
  assign rx_level   = rx_cnt;
  assign status     = {slave_tx_busy_in, rx_full, rx_empty, tx_empty, tx_full, busy_in};
  assign raw_irq    = {(rx_cnt > rx_thr), rx_ovf, rx_unf, tx_ovf, (tx_cnt <= tx_thr)};
  assign masked_irq = raw_irq & irq_mask;
  assign irq        = |masked_irq;

  p_level_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= FULL_LVL) && (rx_level <= FULL_LVL));

  p_tx_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tx_push && !tx_pop && tx_level == FULL_LVL) |=> (tx_level == FULL_LVL) && raw_irq[1]);

  p_rx_unf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rx_pop && rx_level == '0) |=> raw_irq[2] && (rx_level <= LW'(1)));

  p_rx_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_irq[4]) |-> $past(enable && rx_push));

  p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_mask != 5'd0));

  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (tx_level == '0) && (rx_level == '0));

  p_thr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable(tx_thr) && $stable(rx_thr));
endmodule

// File: tb/spi_fifo_irq_unit_tb.sv
module spi_fifo_irq_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int WIDTH = 8;
  localparam int LW = $clog2(DEPTH) + 1;

  // {op[1:0] (1 push, 2 pop), data[7:0], level[6:0], rx irq[0], pop data[7:0]}
  localparam logic [25:0] VEC [8] = '{
    {2'd1, 8'hA1, 7'd1, 1'b0, 8'h00},
    {2'd1, 8'hB2, 7'd2, 1'b0, 8'h00},
    {2'd1, 8'hC3, 7'd3, 1'b1, 8'h00},
    {2'd1, 8'hD4, 7'd4, 1'b1, 8'h00},
    {2'd2, 8'h00, 7'd3, 1'b1, 8'hA1},
    {2'd2, 8'h00, 7'd2, 1'b0, 8'hB2},
    {2'd2, 8'h00, 7'd1, 1'b0, 8'hC3},
    {2'd2, 8'h00, 7'd0, 1'b0, 8'hD4}
  };

  logic clk = 1'b0;
  logic rst_n, enable, busy_in, slave_tx_busy_in;
  logic tx_push, tx_pop, rx_push, rx_pop, tx_thr_wr, rx_thr_wr;
  logic [WIDTH-1:0] tx_wdata, rx_wdata, tx_rdata, rx_rdata;
  logic [LW-1:0] tx_thr_in, rx_thr_in, tx_level, rx_level;
  logic [4:0] irq_mask, raw_irq, masked_irq;
  logic [3:0] clr_bits;
  logic [5:0] status;
  logic irq;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fifo_irq_unit #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .busy_in(busy_in),
    .slave_tx_busy_in(slave_tx_busy_in),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .tx_thr_wr(tx_thr_wr), .tx_thr_in(tx_thr_in), .rx_thr_wr(rx_thr_wr), .rx_thr_in(rx_thr_in),
    .irq_mask(irq_mask), .clr_bits(clr_bits), .tx_level(tx_level), .rx_level(rx_level),
    .status(status), .raw_irq(raw_irq), .masked_irq(masked_irq), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    tx_thr_wr = 0; rx_thr_wr = 0; clr_bits = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; enable = 0; busy_in = 0; slave_tx_busy_in = 0;
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    tx_wdata = '0; rx_wdata = '0; tx_thr_wr = 0; rx_thr_wr = 0;
    tx_thr_in = '0; rx_thr_in = '0; irq_mask = '0; clr_bits = '0;
    tick(); tick();
    rst_n = 1;
    tick();

    chk("R1 tx level", tx_level, 0);
    chk("R1 rx level", rx_level, 0);
    chk("R1/R5 status", status, 6'b001100);
    chk("R1/R6 raw", raw_irq, 5'b00001);
    chk("R8 irq masked off", irq, 0);

    busy_in = 1; slave_tx_busy_in = 1; #1;
    chk("R5 busy bits", status, 6'b101101);
    busy_in = 0; slave_tx_busy_in = 0;

    tx_thr_in = 1; tx_thr_wr = 1; rx_thr_in = 2; rx_thr_wr = 1;
    tick();
    enable = 1;
    tick();

    rx_thr_in = 0; rx_thr_wr = 1;
    tick();
    rx_wdata = 8'h55; rx_push = 1;
    tick();
    chk("R11 rx threshold kept", raw_irq[4], 0);
    chk("R2 rx head", rx_rdata, 8'h55);
    rx_pop = 1;
    tick();
    chk("R2 rx level after pop", rx_level, 0);

    for (int i = 0; i < 8; i++) begin
      if (VEC[i][25:24] == 2'd1) begin
        rx_wdata = VEC[i][23:16]; rx_push = 1;
      end else begin
        chk("R2 rx order", rx_rdata, VEC[i][7:0]);
        rx_pop = 1;
      end
      tick();
      chk("R2 rx level", rx_level, VEC[i][15:9]);
      chk("R7 rx threshold irq", raw_irq[4], VEC[i][8]);
    end

    chk("R6 tx low at 0", raw_irq[0], 1);
    tx_wdata = 8'h11; tx_push = 1; tick();
    chk("R6 tx low at 1", raw_irq[0], 1);
    tx_wdata = 8'h22; tx_push = 1; tick();
    chk("R6 tx low off at 2", raw_irq[0], 0);
    chk("R2 tx head", tx_rdata, 8'h11);
    tx_pop = 1; tick();
    chk("R2 tx second", tx_rdata, 8'h22);
    tx_pop = 1; tick();
    chk("R2 tx empty level", tx_level, 0);
    chk("R2 tx empty data", tx_rdata, 0);

    for (int i = 0; i < DEPTH; i++) begin
      tx_wdata = WIDTH'(i + 8'h40); tx_push = 1; tick();
    end
    chk("R3 tx full level", tx_level, DEPTH);
    chk("R5 tx full/empty bits", status[2:1], 2'b01);
    chk("R3 no ovf yet", raw_irq[1], 0);
    tx_wdata = 8'hEE; tx_push = 1; tick();
    chk("R3 level kept", tx_level, DEPTH);
    chk("R3 tx ovf", raw_irq[1], 1);
    chk("R3 head intact", tx_rdata, 8'h40);

    irq_mask = 5'b00010; #1;
    chk("R8 masked", masked_irq, 5'b00010);
    chk("R8 irq on", irq, 1);
    irq_mask = 5'b00001; #1;
    chk("R8 irq off", irq, 0);
    irq_mask = 5'b00000;

    clr_bits = 4'b1000; tick();
    chk("R9 tx ovf cleared", raw_irq[1], 0);

    chk("R4 empty read zero", rx_rdata, 0);
    rx_pop = 1; tick();
    chk("R4 rx underflow", raw_irq[2], 1);
    chk("R4 rx level stays 0", rx_level, 0);
    for (int i = 0; i < DEPTH; i++) begin
      rx_wdata = WIDTH'(i + 1); rx_push = 1; tick();
    end
    chk("R5 rx full bit", status[4:3], 2'b10);
    rx_wdata = 8'hEE; rx_push = 1; tick();
    chk("R4 rx ovf level", rx_level, DEPTH);
    chk("R4 rx ovf raw", raw_irq, 5'b11100);
    chk("R4 rx head intact", rx_rdata, 8'h01);

    clr_bits = 4'b0010; tick();
    chk("R9 clear underflow only", raw_irq, 5'b11000);
    tx_push = 1; tick();
    chk("R9 tx ovf set again", raw_irq, 5'b11010);
    clr_bits = 4'b0001; tick();
    chk("R9 clear all", raw_irq, 5'b10000);

    enable = 0; tick();
    chk("R10 tx flushed", tx_level, 0);
    chk("R10 rx flushed", rx_level, 0);
    chk("R10 status", status, 6'b001100);
    chk("R10 raw", raw_irq, 5'b00001);
    rx_push = 1; tx_push = 1; rx_pop = 1; tick();
    chk("R10 strobes ignored", {rx_level, tx_level, raw_irq}, {6'd0, 6'd0, 5'b00001});

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule